// File: doc/BRIEF.md
# Saturating Serial Byte-Length Counter

This block measures how long a serial scan transfer was, counted in whole bytes. While the active-low write enable is low, each cycle with the bit strobe high adds one bit. Whole bytes are reported as a compact set of flags: a byte-parity flag, a Johnson code that steps once every two bytes, and a saturation flag that latches at the maximum length. A byte-complete flag tells whether a partial byte followed the last whole byte.

When write enable is released, a short sequencer first captures the flags into holding registers and clears the internal count on the next cycle. Downstream length decoders therefore always see a stable result from the last finished transfer, even while the next transfer is being counted. A decoder can check a length using only the saturation flag, the parity flag, the byte-complete flag and two chosen Johnson bits.

Top module: `serial_len_counter`

## Requirements
- R1: A synchronous active-high reset sets `len_odd`, `len_john` and `len_sat` to 0 and `len_whole` to 1. It also clears the internal count.
- R2: A bit is counted only on a clock edge where `we_n` is 0 and `bit_stb` is 1. Strobes while `we_n` is 1 are ignored. `BYTE_BITS` counted bits (default 8) make one whole byte.
- R3: `len_odd` is 1 when the captured number of whole bytes is odd and 0 when it is even.
- R4: `len_john` (bit 0 is the first stage) holds a Johnson code of whole bytes / 2. For pair counts 0 to 7 it reads 0000, 0001, 0011, 0111, 1111, 1110, 1100 and 1000.
- R5: At 4*`JOHN_W` whole bytes (16 by default), `len_sat` is 1 and `len_odd` and `len_john` are 0. All later strobes of the same transfer are ignored, and `len_whole` reads 1.
- R6: A transfer with fewer than `BYTE_BITS` counted bits reports `len_odd`, `len_john` and `len_sat` all 0.
- R7: The held outputs are loaded on the second rising clock edge after `we_n` is seen going from 0 to 1. The internal count is cleared on the edge after that, so the next transfer starts from zero.
- R8: The held outputs keep their value at all other times, including while the next transfer is being counted.
- R9: `len_whole` is 1 when the captured bit count is a whole number of bytes and 0 when a partial byte trails it.
- R10: The internal Johnson state is always one of the eight legal codes, and a capture pulse is always followed by a clear pulse on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we_n | input | 1 | Active-low write enable, low for the whole transfer |
| bit_stb | input | 1 | One serial bit is present in this cycle |
| len_odd | output | 1 | Held parity of the whole-byte count |
| len_john | output | JOHN_W | Held Johnson code of the byte-pair count, bit 0 is the first stage |
| len_sat | output | 1 | Held saturation flag |
| len_whole | output | 1 | Held flag: no partial byte trailed the transfer |

## Verification
The bench builds the block with its default parameters: `BYTE_BITS` = 8 and `JOHN_W` = 4. With these values, saturation is reached after 128 counted bits, so every Johnson code, the wrap into saturation and strobes past saturation all fit in short transfers. Transfers of every whole length from 0 to 18 bytes are mixed with random lengths, random idle gaps, partial bytes and strobes sent while write enable is high.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

    // Sequencer state: previous write enable, capture pulse, clear pulse
    typedef struct packed {
        logic we_prev;
        logic cap;
        logic clr;
    } sbl_seq_t;

endpackage

// File: rtl/sbl_bit_ctr.sv
module sbl_bit_ctr #(
    parameter int BYTE_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic wrap,
    output logic whole
);
    localparam int BW = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
    localparam logic [BW-1:0] LAST = BW'(BYTE_BITS - 1);

    logic [BW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            if (cnt_q == LAST) begin
                cnt_d = '0;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign whole = (cnt_q == '0);

    // R2: the in-byte count never passes the last bit position
    p_bit_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R10: a clear request leaves the in-byte count at zero
    p_bit_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> whole);

endmodule

// File: rtl/sbl_byte_ctr.sv
module sbl_byte_ctr #(
    parameter int JOHN_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    output logic              odd,
    output logic [JOHN_W-1:0] john,
    output logic              sat
);
    localparam logic [JOHN_W-1:0] JOHN_LAST = JOHN_W'(1) << (JOHN_W - 1);

    typedef struct packed {
        logic              odd;
        logic [JOHN_W-1:0] john;
        logic              sat;
    } byte_st_t;

    byte_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (adv && !st_q.sat) begin
            if (!st_q.odd) begin
                st_d.odd = 1'b1;
            end else if (st_q.john == JOHN_LAST) begin
                st_d = '0;
                st_d.sat = 1'b1;
            end else begin
                st_d.odd  = 1'b0;
                st_d.john = {st_q.john[JOHN_W-2:0], ~st_q.john[JOHN_W-1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign odd  = st_q.odd;
    assign john = st_q.john;
    assign sat  = st_q.sat;

    logic [JOHN_W-2:0] john_edges;
    assign john_edges = st_q.john[JOHN_W-1:1] ^ st_q.john[JOHN_W-2:0];

    // R10: Johnson state is a single contiguous run of ones
    p_john_legal_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(john_edges) <= 1);

    // R5: once saturated the count holds until cleared
    p_sat_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q.sat && !clr) |=> st_q.sat);

    // R5: saturation reads with parity and Johnson at zero
    p_sat_zero_r5: assert property (@(posedge clk) disable iff (rst)
        st_q.sat |-> (!st_q.odd && st_q.john == '0));

    // R7: clear empties the byte count
    p_byte_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st_q == '0));

endmodule

// File: rtl/sbl_seq.sv
module sbl_seq
    import sbl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we_n,
    output logic cap,
    output logic clr
);
    sbl_seq_t sq_d, sq_q;

    always_comb begin
        sq_d         = sq_q;
        sq_d.we_prev = we_n;
        sq_d.cap     = we_n && !sq_q.we_prev;
        sq_d.clr     = sq_q.cap;
    end

    always_ff @(posedge clk) begin
        if (rst) sq_q <= '{we_prev: 1'b1, cap: 1'b0, clr: 1'b0};
        else     sq_q <= sq_d;
    end

    assign cap = sq_q.cap;
    assign clr = sq_q.clr;

    // R10: every capture is followed by a clear on the next cycle
    p_cap_then_clr_r10: assert property (@(posedge clk) disable iff (rst)
        cap |=> clr);

    // R7: capture and clear never overlap
    p_cap_clr_apart_r7: assert property (@(posedge clk) disable iff (rst)
        !(cap && clr));

endmodule

// File: rtl/serial_len_counter.sv
module serial_len_counter #(
    parameter int BYTE_BITS = 8,
    parameter int JOHN_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_n,
    input  logic              bit_stb,
    output logic              len_odd,
    output logic [JOHN_W-1:0] len_john,
    output logic              len_sat,
    output logic              len_whole
);
    typedef struct packed {
        logic              odd;
        logic [JOHN_W-1:0] john;
        logic              sat;
        logic              whole;
    } held_t;

    logic              cap, clr;
    logic              step, wrap, whole_int;
    logic              odd_int, sat_int;
    logic [JOHN_W-1:0] john_int;
    held_t             held_d, held_q;

    sbl_seq i_seq (
        .clk (clk),
        .rst (rst),
        .we_n(we_n),
        .cap (cap),
        .clr (clr)
    );

    assign step = !we_n && bit_stb && !clr && !sat_int;

    sbl_bit_ctr #(.BYTE_BITS(BYTE_BITS)) i_bits (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .step (step),
        .wrap (wrap),
        .whole(whole_int)
    );

    sbl_byte_ctr #(.JOHN_W(JOHN_W)) i_bytes (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .adv (wrap),
        .odd (odd_int),
        .john(john_int),
        .sat (sat_int)
    );

    always_comb begin
        held_d = held_q;
        if (cap) begin
            held_d.odd   = odd_int;
            held_d.john  = john_int;
            held_d.sat   = sat_int;
            held_d.whole = whole_int;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) held_q <= '{odd: 1'b0, john: '0, sat: 1'b0, whole: 1'b1};
        else     held_q <= held_d;
    end

    assign len_odd   = held_q.odd;
    assign len_john  = held_q.john;
    assign len_sat   = held_q.sat;
    assign len_whole = held_q.whole;

    // R8: held outputs move only one cycle after a capture pulse
    p_held_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(held_q));

    // R5: a held saturated length shows no parity or Johnson bits
    p_held_sat_r5: assert property (@(posedge clk) disable iff (rst)
        len_sat |-> (!len_odd && len_john == '0 && len_whole));

    // R2: nothing is counted while write enable is high
    p_no_count_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (we_n && !clr) |=> ($stable(odd_int) && $stable(john_int) && $stable(sat_int)));

endmodule

// File: tb/test_serial_len_counter.sv
module test_serial_len_counter;
    localparam int BYTE_BITS = 8;
    localparam int JOHN_W    = 4;
    localparam int SAT_BYTES = 4 * JOHN_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              we_n;
    logic              bit_stb;
    logic              len_odd;
    logic [JOHN_W-1:0] len_john;
    logic              len_sat;
    logic              len_whole;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    serial_len_counter #(.BYTE_BITS(BYTE_BITS), .JOHN_W(JOHN_W)) i_serial_len_counter (
        .clk      (clk),
        .rst      (rst),
        .we_n     (we_n),
        .bit_stb  (bit_stb),
        .len_odd  (len_odd),
        .len_john (len_john),
        .len_sat  (len_sat),
        .len_whole(len_whole)
    );

    // expected packed flags {odd, john, sat, whole} for a given bit count
    function automatic logic [JOHN_W+2:0] expect_flags(int nbits);
        int bytes, pairs;
        logic [JOHN_W-1:0] j;
        if (nbits >= SAT_BYTES * BYTE_BITS) return {1'b0, {JOHN_W{1'b0}}, 1'b1, 1'b1};
        bytes = nbits / BYTE_BITS;
        pairs = bytes / 2;
        if (pairs < JOHN_W) j = JOHN_W'((1 << pairs) - 1);
        else                j = JOHN_W'({JOHN_W{1'b1}} << (pairs - JOHN_W));
        return {1'(bytes % 2), j, 1'b0, 1'((nbits % BYTE_BITS) == 0)};
    endfunction

    function automatic logic [JOHN_W+2:0] actual_flags();
        return {len_odd, len_john, len_sat, len_whole};
    endfunction

    task automatic chk(string req, logic [JOHN_W+2:0] act, logic [JOHN_W+2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    logic [JOHN_W+2:0] prev_exp;

    // one transfer with nstb strobes; stray strobes while we_n is high before it
    task automatic xfer(int nstb, int max_gap, int stray, string req);
        for (int i = 0; i < stray; i++) begin
            @(negedge clk); we_n = 1'b1; bit_stb = 1'b1;
        end
        @(negedge clk); bit_stb = 1'b0; we_n = 1'b0;
        for (int i = 0; i < nstb; i++) begin
            int g = (max_gap > 0) ? int'($urandom_range(max_gap, 0)) : 0;
            for (int k = 0; k < g; k++) begin
                @(negedge clk); bit_stb = 1'b0;
            end
            @(negedge clk); bit_stb = 1'b1;
        end
        @(negedge clk); bit_stb = 1'b0;
        chk("R8 held during transfer", actual_flags(), prev_exp);
        we_n = 1'b1;
        @(negedge clk);
        chk("R8 held before capture", actual_flags(), prev_exp);
        @(negedge clk);
        @(negedge clk);
        prev_exp = expect_flags(nstb);
        chk(req, actual_flags(), prev_exp);
    endtask

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; we_n = 1'b1; bit_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        prev_exp = {1'b0, {JOHN_W{1'b0}}, 1'b0, 1'b1};
        chk("R1 reset state", actual_flags(), prev_exp);

        // R6 / R9: empty and partial-byte transfers
        xfer(0, 0, 0, "R6 empty transfer");
        xfer(BYTE_BITS - 1, 1, 0, "R6 R9 partial first byte");
        // R3 / R4 / R5: every whole length, past saturation
        for (int b = 0; b <= SAT_BYTES + 2; b++)
            xfer(b * BYTE_BITS, 0, 0, "R3 R4 whole bytes");
        // R5: just below, at and beyond saturation with partial bits
        xfer(SAT_BYTES * BYTE_BITS - 1, 0, 0, "R5 R9 one bit short");
        xfer(SAT_BYTES * BYTE_BITS + 3, 0, 0, "R5 strobes after saturation");
        // R2: strobes with write enable high are ignored
        xfer(3 * BYTE_BITS, 2, 5, "R2 stray strobes ignored");
        // R7: back-to-back transfer restarts from zero
        xfer(BYTE_BITS + 2, 0, 0, "R7 R9 restart after clear");
        // random mix
        for (int n = 0; n < 60; n++) begin
            int len = int'($urandom_range(SAT_BYTES * BYTE_BITS + 10, 0));
            if ($urandom_range(1, 0) == 0) len = (len / BYTE_BITS) * BYTE_BITS;
            xfer(len, int'($urandom_range(3, 0)), int'($urandom_range(2, 0)), "R2 R3 R4 R9 random");
        end

        // R1: reset in the middle of a transfer
        @(negedge clk); we_n = 1'b0; bit_stb = 1'b1;
        repeat (20) @(negedge clk);
        rst = 1'b1; bit_stb = 1'b0; we_n = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        prev_exp = {1'b0, {JOHN_W{1'b0}}, 1'b0, 1'b1};
        chk("R1 reset mid transfer", actual_flags(), prev_exp);
        xfer(2 * BYTE_BITS, 0, 0, "R1 R7 count after reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule